// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier

This block multiplies two signed two's-complement operands over several clock cycles, using a single adder and one working shift register. A pulse on `start` captures the multiplicand and multiplier; the unit then retires one multiplier bit per cycle. In each step it inspects the two lowest bits of the working register and adds the prepared multiplicand or its negation, or adds nothing. It then shifts the register right arithmetically by one place.

After as many steps as the multiplier has bits, the guard bit at the bottom of the working register is discarded and the result is loaded into the product register. `done` pulses for one cycle at that point. The product register then keeps its value until the next operation completes. The multiplicand is sign-extended by one bit inside the block, so negating the most negative multiplicand cannot overflow.

Top module: `booth_seq_mul`

## Requirements
- R1: When an operation completes, `product` equals the signed product of the captured `x_in` and `y_in`, taken as two's-complement numbers and written as a two's-complement value of XW+YW bits.
- R2: The product is also correct when either operand, or both, is the most negative value of its width.
- R3: A `start` seen while `busy` is low is accepted on that clock edge. `busy` is high from the next cycle for exactly YW cycles.
- R4: `done` is high for exactly one cycle, the cycle right after the last cycle of `busy`, and it is high at no other time.
- R5: A `start` pulse while `busy` is high has no effect. The running operation finishes on schedule with its original operands.
- R6: `product` changes only on the edge that raises `done`. It holds its value at every other time.
- R7: After reset, `busy` and `done` are low and `product` is zero.
- R8: `x_in` and `y_in` are captured only when a start is accepted. Changing them while `busy` is high does not change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| x_in | input | XW | Signed multiplicand |
| y_in | input | YW | Signed multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | XW+YW | Signed result, held between completions |

## Verification
The bench aims at the most negative multiplicand. A design that negates it at its own width would turn the subtract constant back into the same negative value and return a result with the wrong sign. It also covers operands at the most negative and most positive values and every pairing of signs, where a design that shifted logically instead of arithmetically would lose the sign of negative partial results. Start pulses during a run and operand changes during a run target a design that restarts or samples its inputs again mid-run, which would give a wrong product or stretch `busy`. A start issued in the very cycle `done` is high checks that back-to-back operations neither lose a cycle nor corrupt the held product.

// File: rtl/booth_seq_mul.sv
module booth_seq_mul #(
  parameter int XW = 16,
  parameter int YW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [XW-1:0]      x_in,
  input  logic [YW-1:0]      y_in,
  output logic               busy,
  output logic               done,
  output logic [XW+YW-1:0]   product
);
  localparam int PW  = XW + YW + 2;
  localparam int PRW = XW + YW;
  localparam int CW  = $clog2(YW + 1);

  logic [PW-1:0] acc, add_pos, add_neg, sum, nxt;
  logic [CW-1:0] steps;
  logic [XW:0]   x_ext;

  assign x_ext = {x_in[XW-1], x_in};

  always_comb begin
    unique case (acc[1:0])
      2'b01:   sum = acc + add_pos;
      2'b10:   sum = acc + add_neg;
      default: sum = acc;
    endcase
  end

  assign nxt = {sum[PW-1], sum[PW-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      add_pos <= '0;
      add_neg <= '0;
      steps   <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      product <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          add_pos <= {x_ext, {(YW+1){1'b0}}};
          add_neg <= {-x_ext, {(YW+1){1'b0}}};
          acc     <= {{(XW+1){1'b0}}, y_in, 1'b0};
          steps   <= CW'(YW);
          busy    <= 1'b1;
        end
      end else begin
        acc   <= nxt;
        steps <= steps - 1'b1;
        if (steps == CW'(1)) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          product <= nxt[PRW:1];
        end
      end
    end
  end
endmodule

module booth_seq_mul_chk #(
  parameter int XW = 16,
  parameter int YW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [XW+YW-1:0] product
);
  int unsigned busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= 0;
    else        busy_run <= busy ? busy_run + 1 : 0;
  end

  a_r3_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_run == YW);

  a_r3_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r4_done_follows_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  a_r4_done_only_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy || $past(busy));

  a_r5_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && busy_run < YW - 1) |=> busy);

  a_r6_product_held: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(product));
endmodule

bind booth_seq_mul booth_seq_mul_chk #(.XW(XW), .YW(YW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .busy(busy), .done(done), .product(product)
);

// File: tb/booth_seq_mul_tb.sv
module booth_seq_mul_tb;
  localparam int XW  = 16;
  localparam int YW  = 16;
  localparam int PRW = XW + YW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [XW-1:0] x_in = '0;
  logic [YW-1:0] y_in = '0;
  logic busy, done;
  logic [PRW-1:0] product;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  booth_seq_mul #(.XW(XW), .YW(YW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .y_in(y_in),
    .busy(busy), .done(done), .product(product)
  );

  // behavioural reference
  int m_left = 0;
  logic m_done = 1'b0;
  logic signed [PRW-1:0] m_prod = '0;
  logic signed [PRW-1:0] m_pending = '0;

  always @(posedge clk) begin
    if (rst_n) begin
      m_done = 1'b0;
      if (m_left == 0) begin
        if (start) begin
          m_pending = $signed(x_in) * $signed(y_in);
          m_left = YW;
        end
      end else begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          m_done = 1'b1;
          m_prod = m_pending;
        end
      end
    end
  end

  task automatic check(input string tag, input logic [PRW-1:0] act, input logic [PRW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R3 busy", PRW'(busy), PRW'(m_left > 0));
      check("R4 done", PRW'(done), PRW'(m_done));
      check("R6 product", product, m_prod);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run(input logic [XW-1:0] a, input logic [YW-1:0] b, input string tag);
    logic signed [PRW-1:0] e;
    e = $signed(a) * $signed(b);
    @(negedge clk);
    start = 1'b1; x_in = a; y_in = b;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check(tag, product, e);
  endtask

  initial begin
    logic signed [PRW-1:0] e;
    repeat (3) @(negedge clk);
    check("R7 busy", PRW'(busy), '0);
    check("R7 done", PRW'(done), '0);
    check("R7 product", product, '0);
    rst_n = 1'b1;

    run(16'd3, 16'd5, "R1 pos*pos");
    run(-16'sd3, 16'd5, "R1 neg*pos");
    run(16'd3, -16'sd5, "R1 pos*neg");
    run(-16'sd3, -16'sd5, "R1 neg*neg");
    run(16'd0, 16'h1234, "R1 zero");
    run(16'h7fff, 16'h7fff, "R1 max*max");
    run(16'h8000, 16'd1, "R2 xmin*1");
    run(16'h8000, 16'hffff, "R2 xmin*-1");
    run(16'h8000, 16'h7fff, "R2 xmin*max");
    run(16'd1, 16'h8000, "R2 1*ymin");
    run(16'h8000, 16'h8000, "R2 min*min");
    for (int i = 0; i < 40; i++) run(XW'($urandom), YW'($urandom), "R1 random");

    // R5 and R8: start pulses and operand changes during a run
    e = $signed(16'sd1234) * $signed(-16'sd77);
    @(negedge clk);
    start = 1'b1; x_in = 16'sd1234; y_in = -16'sd77;
    @(negedge clk);
    x_in = 16'h5555; y_in = 16'haaaa;
    repeat (4) @(negedge clk);
    start = 1'b0;
    x_in = 16'h0f0f;
    while (!done) @(negedge clk);
    check("R5/R8 operands held", product, e);

    // back-to-back start in the done cycle (R3)
    e = $signed(-16'sd9) * $signed(16'sd11);
    start = 1'b1; x_in = -16'sd9; y_in = 16'sd11;
    @(negedge clk);
    start = 1'b0;
    check("R3 accepted in done cycle", PRW'(busy), PRW'(1));
    while (!done) @(negedge clk);
    check("R3 back-to-back product", product, e);

    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule